// File: doc/BRIEF.md
# Serial word framer with overclock cadence

This block turns 12-bit parallel words into a continuous serial stream in the bit-clock domain. A word presented with a one-cycle strobe pulse is stored in a holding register. At the next frame boundary it is moved into a shift register and sent most significant bit first, one bit per clock. After the data come two framing bits, a one and then a zero, which let a receiver find the word boundary. A frame-start marker is high during the first slot of every frame.

Two cadences are supported. In standard cadence every frame is 14 slots long. In overclocked cadence the frame lengths cycle through 14, 14, 16, and the two extra slots of the long frame carry zeros. When no word is waiting at a frame boundary, the frame that follows is all zeros. This covers the case where the bit clock runs faster than words arrive.

A power-down input clears every register, discards any held word and drops the serial output enable. When power-down is released the block restarts at the first frame of the cadence.

Top module: `serial_word_framer`

## Requirements
- R1: A word sampled on a cycle with `strobePulse` high is sent in the next frame that begins after that cycle's frame ends. `wordIn[11]` goes in slot 0 and `wordIn[0]` in slot 11.
- R2: In every frame that carries a word, slot 12 is 1 and slot 13 is 0.
- R3: With `overclock` low, every frame is 14 slots long, and `frameStart` is high only in slot 0.
- R4: With `overclock` high, frame lengths repeat as 14, 14, 16. The length of a frame is set by `overclock` as sampled in the last slot of the frame before it. A standard-cadence frame returns the cadence to its first position.
- R5: Slots 14 and 15 of a 16-slot frame are always 0.
- R6: If no word is held when a frame ends, the next frame is all zeros and has the length the cadence gives.
- R7: A strobe that arrives while a word is already held, outside a frame's last slot, raises `overrun` for exactly one cycle on the following cycle. The newer word replaces the held one.
- R8: A strobe in a frame's last slot while a word is held sends the held word in the next frame and keeps the new word for the frame after. `overrun` stays low.
- R9: While `pwrDown` is high, from the cycle after it is sampled, `serOe`, `serBit`, `frameStart` and `overrun` are low and any held word is discarded.
- R10: After `pwrDown` is sampled low, `serOe` and `frameStart` go high on the next cycle. That frame is at the first cadence position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | Synchronous power-down and clear |
| overclock | input | 1 | Cadence select: 0 standard, 1 overclocked |
| strobePulse | input | 1 | One-cycle pulse marking a strobe rising edge |
| wordIn | input | 12 | Parallel word sampled with the strobe |
| serBit | output | 1 | Serial data bit |
| serOe | output | 1 | Serial output enable (low means idle, high impedance) |
| frameStart | output | 1 | High during slot 0 of each frame |
| overrun | output | 1 | One-cycle pulse when a held word is replaced |

## Verification
A table of words is driven one per frame. The words include all-ones, all-zeros-but-one-bit and alternating patterns, so a bit-order or slot-offset error changes the received frame. The table switches between cadences and leaves gaps without strobes. These tell apart a correct 14/14/16 rotation from a wrong length, a wrong restart point or a select sampled at the wrong time, and show that idle frames are all zeros. Directed cases then strobe twice in one frame, strobe in the last slot of a frame, and cut power in the middle of a frame with a word held. These separate replacing a held word from losing it, and show that the cadence restarts from its first position.

// File: rtl/framer_pkg.sv
`timescale 1ns/1ps
package framer_pkg;

  // Strobes from the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic clearAll;   // power-down: drop everything
    logic capture;    // take wordIn into the holding register
    logic frameEnd;   // last slot of the current frame
    logic loadWord;   // frameEnd with a word held: load it
    logic shiftEn;    // advance the shift register by one slot
  } fr_ctrl_t;

endpackage

// File: rtl/fr_ctrl.sv
`timescale 1ns/1ps
module fr_ctrl
  import framer_pkg::*;
#(
  parameter int FRAME_W = 14,
  parameter int LONG_W  = 16,
  parameter int CAD_LEN = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrDown,
  input  logic     overclock,
  input  logic     strobePulse,
  output fr_ctrl_t ctrl,
  output logic     active,
  output logic     frameStart,
  output logic     overrun
);

  localparam int SLOT_W = $clog2(LONG_W);
  localparam int CAD_W  = $clog2(CAD_LEN + 1);
  localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(FRAME_W - 1);
  localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(LONG_W - 1);
  localparam logic [CAD_W-1:0]  CAD_LAST   = CAD_W'(CAD_LEN - 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] lastSlot;
  logic [CAD_W-1:0]  cadIdx;
  logic [CAD_W-1:0]  cadNext;
  logic              curLong;
  logic              holdValid;
  logic              overrunQ;
  logic              frameEnd;
  logic              consume;

  assign lastSlot = curLong ? LONG_LAST : SHORT_LAST;
  assign frameEnd = active && (slotCnt == lastSlot);
  assign consume  = frameEnd && holdValid;

  // Cadence position for the frame that follows the current one.
  always_comb begin
    if (!overclock) begin
      cadNext = '0;
    end else if (cadIdx == CAD_LAST) begin
      cadNext = '0;
    end else begin
      cadNext = cadIdx + CAD_W'(1);
    end
  end

  // Slot counter, cadence position and frame length.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotCnt <= '0;
      cadIdx  <= '0;
      curLong <= 1'b0;
    end else if (pwrDown) begin
      active  <= 1'b0;
      slotCnt <= '0;
      cadIdx  <= '0;
      curLong <= 1'b0;
    end else begin
      active <= 1'b1;
      if (active) begin
        if (frameEnd) begin
          slotCnt <= '0;
          cadIdx  <= cadNext;
          curLong <= overclock && (cadNext == CAD_LAST);
        end else begin
          slotCnt <= slotCnt + SLOT_W'(1);
        end
      end
    end
  end

  // Holding-register occupancy and overrun detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      overrunQ  <= 1'b0;
    end else if (pwrDown) begin
      holdValid <= 1'b0;
      overrunQ  <= 1'b0;
    end else begin
      overrunQ <= strobePulse && holdValid && !consume;
      if (strobePulse) begin
        holdValid <= 1'b1;
      end else if (consume) begin
        holdValid <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl.clearAll = pwrDown;
    ctrl.capture  = strobePulse && !pwrDown;
    ctrl.frameEnd = frameEnd && !pwrDown;
    ctrl.loadWord = consume && !pwrDown;
    ctrl.shiftEn  = active && !frameEnd && !pwrDown;
  end

  assign frameStart = active && (slotCnt == '0);
  assign overrun    = overrunQ;

endmodule

// File: rtl/fr_dpath.sv
`timescale 1ns/1ps
module fr_dpath
  import framer_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int MARK_W = 2,
  parameter logic [MARK_W-1:0] MARK_PAT = 2'b10,
  parameter int LONG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fr_ctrl_t          ctrl,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serMsb
);

  localparam int PAD_W = LONG_W - WORD_W - MARK_W;

  logic [WORD_W-1:0] holdWord;
  logic [LONG_W-1:0] shiftReg;
  logic [LONG_W-1:0] loadVal;

  // Frame image: data MSB-first, framing bits, then zero padding.
  generate
    if (PAD_W > 0) begin : g_pad
      assign loadVal = {holdWord, MARK_PAT, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign loadVal = {holdWord, MARK_PAT};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else if (ctrl.clearAll) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else begin
      if (ctrl.capture) begin
        holdWord <= wordIn;
      end
      if (ctrl.frameEnd) begin
        shiftReg <= ctrl.loadWord ? loadVal : '0;
      end else if (ctrl.shiftEn) begin
        shiftReg <= {shiftReg[LONG_W-2:0], 1'b0};
      end
    end
  end

  assign serMsb = shiftReg[LONG_W-1];

endmodule

// File: rtl/serial_word_framer.sv
`timescale 1ns/1ps
module serial_word_framer
  import framer_pkg::*;
#(
  parameter int WORD_W  = 12,
  parameter int MARK_W  = 2,
  parameter int PAD_W   = 2,
  parameter int CAD_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDown,
  input  logic              overclock,
  input  logic              strobePulse,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serBit,
  output logic              serOe,
  output logic              frameStart,
  output logic              overrun
);

  localparam int FRAME_W = WORD_W + MARK_W;
  localparam int LONG_W  = FRAME_W + PAD_W;

  fr_ctrl_t ctrl;
  logic     active;
  logic     serMsb;

  fr_ctrl #(
    .FRAME_W (FRAME_W),
    .LONG_W  (LONG_W),
    .CAD_LEN (CAD_LEN)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .pwrDown     (pwrDown),
    .overclock   (overclock),
    .strobePulse (strobePulse),
    .ctrl        (ctrl),
    .active      (active),
    .frameStart  (frameStart),
    .overrun     (overrun)
  );

  fr_dpath #(
    .WORD_W   (WORD_W),
    .MARK_W   (MARK_W),
    .MARK_PAT (MARK_W'(2'b10)),
    .LONG_W   (LONG_W)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .wordIn (wordIn),
    .serMsb (serMsb)
  );

  assign serOe  = active;
  assign serBit = active && serMsb;

endmodule

// File: rtl/serial_word_framer_chk.sv
`timescale 1ns/1ps
module serial_word_framer_chk (
  input logic clk,
  input logic rstN,
  input logic pwrDown,
  input logic overclock,
  input logic strobePulse,
  input logic serBit,
  input logic serOe,
  input logic frameStart,
  input logic overrun
);

  // Slots seen since the last frame start, observed at the ports only.
  logic [4:0] seen;
  logic       started;
  logic       lastOc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen    <= '0;
      started <= 1'b0;
      lastOc  <= 1'b0;
    end else begin
      lastOc <= overclock;
      if (!serOe) begin
        seen    <= '0;
        started <= 1'b0;
      end else if (frameStart) begin
        seen    <= 5'd1;
        started <= 1'b1;
      end else if (seen != 5'd31) begin
        seen <= seen + 5'd1;
      end
    end
  end

  AST_PD_OE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (!serOe && !serBit && !frameStart && !overrun)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !serOe |-> (!serBit && !frameStart)); // R9

  AST_RELEASE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrDown && !serOe) |=> (serOe && frameStart)); // R10

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && frameStart && started) |-> (seen == 5'd14 || seen == 5'd16)); // R4

  AST_STD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && frameStart && started && !lastOc && !$past(lastOc)) |-> (seen == 5'd14)); // R3

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && !frameStart && seen >= 5'd14) |-> !serBit); // R5

  AST_MARK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && !frameStart && seen == 5'd13) |-> !serBit); // R2

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> ($past(strobePulse) && !$past(pwrDown))); // R7

  AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !strobePulse) |=> !overrun); // R7

endmodule

bind serial_word_framer serial_word_framer_chk chk_i (.*);

// File: tb/serial_word_framer_tb.sv
`timescale 1ns/1ps
module serial_word_framer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrDown = 1'b1;
  logic        overclock = 1'b0;
  logic        strobePulse = 1'b0;
  logic [11:0] wordIn = '0;
  logic        serBit;
  logic        serOe;
  logic        frameStart;
  logic        overrun;

  int checkCnt = 0;
  int failCnt  = 0;
  bit watchdogHit = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serial_word_framer dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .pwrDown     (pwrDown),
    .overclock   (overclock),
    .strobePulse (strobePulse),
    .wordIn      (wordIn),
    .serBit      (serBit),
    .serOe       (serOe),
    .frameStart  (frameStart),
    .overrun     (overrun)
  );

  // Vector: [13] strobe this frame, [12] cadence select, [11:0] word.
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'hA5C}, {1'b1, 1'b0, 12'h3F0}, {1'b0, 1'b0, 12'h000},
    {1'b1, 1'b0, 12'h001}, {1'b1, 1'b1, 12'hFFF}, {1'b1, 1'b1, 12'h800},
    {1'b1, 1'b1, 12'h555}, {1'b0, 1'b1, 12'h000}, {1'b1, 1'b1, 12'hAAA},
    {1'b1, 1'b1, 12'h0F3}, {1'b1, 1'b1, 12'h924}, {1'b1, 1'b0, 12'h6DB},
    {1'b1, 1'b1, 12'h111}, {1'b0, 1'b1, 12'h000}, {1'b1, 1'b1, 12'hC3C},
    {1'b1, 1'b0, 12'h777}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at the negedge of slot 0; returns at the negedge of the next slot 0.
  task automatic grabFrame(output logic [15:0] bits, output int len);
    bits = '0;
    bits[15] = serBit;
    len = 1;
    forever begin
      @(negedge clk);
      strobePulse = 1'b0;
      if (frameStart || len > 40) break;
      if (len < 16) bits[15-len] = serBit;
      len++;
    end
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!frameStart);
  endtask

  function automatic logic [15:0] dataFrame(input logic [11:0] w);
    return {w, 2'b10, 2'b00};
  endfunction

  task automatic runAll();
    logic [15:0] bits;
    int          len;
    logic [15:0] expBits;
    int          expLen;
    int          cad;
    logic [13:0] v;
    logic [15:0] wordB;

    // Reset state (R9)
    repeat (3) @(negedge clk);
    check(!serOe && !serBit && !frameStart && !overrun, "R9 reset",
          {serOe, serBit, frameStart, overrun}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!serOe && !frameStart, "R9 held in power-down", {serOe, frameStart}, 0);
    pwrDown = 1'b0;
    @(negedge clk);
    check(serOe && frameStart, "R10 release", {serOe, frameStart}, 2'b11);

    // Table walk: one frame per vector, plus a drain frame.
    expBits = '0;
    expLen  = 14;
    cad     = 0;
    for (int i = 0; i <= NV; i++) begin
      v = (i < NV) ? VEC[i] : {1'b0, 1'b0, 12'h000};
      overclock = v[12];
      if (v[13]) begin
        strobePulse = 1'b1;
        wordIn = v[11:0];
      end
      grabFrame(bits, len);
      check(len == expLen, (expLen == 16) ? "R4 R5 length" : "R3 R4 length", len, expLen);
      check(bits == expBits, (expBits == 0) ? "R6 idle frame" : "R1 R2 data frame",
            bits, expBits);
      cad = v[12] ? ((cad == 2) ? 0 : cad + 1) : 0;
      expLen  = (v[12] && cad == 2) ? 16 : 14;
      expBits = v[13] ? dataFrame(v[11:0]) : 16'h0000;
    end

    // Overrun: two strobes in one frame (R7). Standard cadence now.
    strobePulse = 1'b1;
    wordIn = 12'h123;
    @(negedge clk);
    wordB = 16'(12'h456);
    wordIn = wordB[11:0];
    @(negedge clk);
    strobePulse = 1'b0;
    check(overrun == 1'b1, "R7 overrun raised", overrun, 1);
    @(negedge clk);
    check(overrun == 1'b0, "R7 overrun one cycle", overrun, 0);
    waitStart();
    grabFrame(bits, len);
    check(bits == dataFrame(12'h456) && len == 14, "R7 newer word kept", bits,
          dataFrame(12'h456));

    // Strobe in the last slot with a word held (R8).
    strobePulse = 1'b1;
    wordIn = 12'hBEE;
    @(negedge clk);
    strobePulse = 1'b0;
    repeat (12) @(negedge clk);
    strobePulse = 1'b1;
    wordIn = 12'h0D1;
    @(negedge clk);
    strobePulse = 1'b0;
    check(overrun == 1'b0, "R8 no overrun at boundary", overrun, 0);
    check(frameStart == 1'b1, "R8 boundary reached", frameStart, 1);
    grabFrame(bits, len);
    check(bits == dataFrame(12'hBEE), "R8 held word first", bits, dataFrame(12'hBEE));
    grabFrame(bits, len);
    check(bits == dataFrame(12'h0D1), "R8 late word second", bits, dataFrame(12'h0D1));

    // Power-down mid-frame with a word held (R9, R10).
    overclock = 1'b1;
    strobePulse = 1'b1;
    wordIn = 12'hF0F;
    @(negedge clk);
    strobePulse = 1'b0;
    @(negedge clk);
    pwrDown = 1'b1;
    @(negedge clk);
    check(!serOe && !serBit && !frameStart && !overrun, "R9 power-down outputs",
          {serOe, serBit, frameStart, overrun}, 0);
    repeat (3) @(negedge clk);
    pwrDown = 1'b0;
    @(negedge clk);
    check(serOe && frameStart, "R10 restart", {serOe, frameStart}, 2'b11);
    grabFrame(bits, len);
    check(bits == 16'h0000, "R9 held word discarded", bits, 0);
    check(len == 14, "R10 cadence first frame", len, 14);
    grabFrame(bits, len);
    check(len == 14 && bits == 16'h0000, "R10 cadence second frame", len, 14);
    grabFrame(bits, len);
    check(len == 16 && bits == 16'h0000, "R4 cadence long frame after restart", len, 16);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (200000) @(posedge clk);
        watchdogHit = 1'b1;
      end
    join_any
    if (watchdogHit) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule